// File: doc/BRIEF.md
# Performance Event Counter Unit

The unit holds six 32-bit event counters fed by single-cycle pulses from a processor core. Four of them are general-purpose. Each takes a 20-bit event code from its own select register. The leading hex digit of the code must name that counter, and the low byte picks one of sixteen core events. The last two counters always track completed run instructions and run cycles.

A control register holds three things: a global freeze bit, an alert-enable bit and a two-bit mode field. With the mode at 3, the two run counters leave monitor control. The freeze bit no longer stops them and their sign bits raise no alert. They keep counting all the same. Software reads and writes every register through a single-cycle port with combinational read data.

Top module: `perf_monitor`

## Requirements
- R1: Event input bit positions are: 0 floating-point op done, 1 load done, 2 store done, 3 instruction-cache miss, 4 instruction-TLB miss, 5 instruction-TLB miss resolved, 6 data-cache load miss, 7 data-cache load miss resolved, 8 data-cache store miss, 9 data-TLB miss, 10 data-TLB miss resolved, 11 no instruction available and none executing, 12 instruction dispatched, 13 taken branch done, 14 branch mispredicted, 15 external interrupt taken. General counter k (1..4) adds one per cycle its event bit is high, for these codes: 0x100F4→0, 0x100FC→1, 0x100F6→4, 0x100F8→11; 0x200F0→2, 0x200FC→3, 0x200F6→10, 0x200F2→12, 0x200FA→13, 0x200F8→15; 0x300F8→7, 0x300F0→8, 0x300FC→9, 0x300F2→12; 0x400FC→5, 0x400F0→6, 0x400F6→14, 0x400F2→12.
- R2: A select value that is not in that list leaves its counter unchanged. This includes a valid code placed in another counter's select register.
- R3: Counter 5 adds one per cycle that `run_inst` is high. Counter 6 adds one per cycle that `run_cyc` is high.
- R4: With control bit 0 (freeze) set, counters 1 to 4 hold their values. With the mode field (control bits 3:2) not equal to 3, freeze also holds counters 5 and 6.
- R5: With the mode field equal to 3, counters 5 and 6 keep counting while freeze is set.
- R6: While control bit 1 (alert enable) is set, `alert` rises one cycle after a monitored counter's bit 31 becomes set. It then stays high as long as alert enable remains set.
- R7: `alert` is low in the cycle after one in which alert enable was clear.
- R8: Bit 31 of counter 5 or 6 raises `alert` when the mode field is not 3, and never raises it when the mode field is 3.
- R9: A register write to a counter takes effect over an increment of that counter in the same cycle.
- R10: Address map: 0 is control (bits 3:0), 1 to 4 are the 20-bit select registers of counters 1 to 4, and 8 to 13 are counters 1 to 6. Other addresses read zero. Every register and `alert` reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data at `addr` |
| ev | input | 16 | Core event pulses |
| run_inst | input | 1 | Run instruction completed pulse |
| run_cyc | input | 1 | Run cycle pulse |
| alert | output | 1 | Performance alert level |

## Verification
A software write to a counter and an event increment of that same counter can land on one clock edge. The bench provokes this by raising the selected event bit in the same cycle as a counter write. It then requires the counter to read back exactly the written value, with no extra count. A second coincidence places the freeze bit alongside mode 3 while both run pulses are active. In that case the general counters must hold and the two run counters must still advance by exactly one per pulse.

// File: rtl/perf_monitor.sv
module perf_monitor #(
  parameter int CW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  input  logic [15:0]   ev,
  input  logic          run_inst,
  input  logic          run_cyc,
  output logic          alert
);
  localparam int SW = 20;
  localparam int NG = 4;
  localparam int NC = 6;
  localparam logic [AW-1:0] CNT_BASE = AW'(8);

  logic [3:0]    ctrl_q;
  logic [SW-1:0] sel_q [NG];
  logic [CW-1:0] cnt_q [NC];
  logic [NC-1:0] tops;
  logic          alert_q;

  wire frz  = ctrl_q[0];
  wire a_en = ctrl_q[1];
  wire free = (ctrl_q[3:2] == 2'b11);

  function automatic logic [4:0] decode(input logic [SW-1:0] c);
    case (c)
      20'h100F4: return 5'h10;
      20'h100FC: return 5'h11;
      20'h100F6: return 5'h14;
      20'h100F8: return 5'h1B;
      20'h200F0: return 5'h12;
      20'h200FC: return 5'h13;
      20'h200F6: return 5'h1A;
      20'h200F2: return 5'h1C;
      20'h200FA: return 5'h1D;
      20'h200F8: return 5'h1F;
      20'h300F8: return 5'h17;
      20'h300F0: return 5'h18;
      20'h300FC: return 5'h19;
      20'h300F2: return 5'h1C;
      20'h400FC: return 5'h15;
      20'h400F0: return 5'h16;
      20'h400F6: return 5'h1E;
      20'h400F2: return 5'h1C;
      default:   return 5'h00;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl_q <= '0;
    else if (wr_en && addr == '0) ctrl_q <= wdata[3:0];

  for (genvar g = 0; g < NG; g++) begin : g_gen
    logic [4:0] d;
    logic       inc;
    assign d   = decode(sel_q[g]);
    assign inc = !frz && d[4] && (sel_q[g][19:16] == 4'(g + 1)) && ev[d[3:0]];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sel_q[g] <= '0;
      else if (wr_en && addr == AW'(g + 1)) sel_q[g] <= wdata[SW-1:0];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cnt_q[g] <= '0;
      else if (wr_en && addr == CNT_BASE + AW'(g)) cnt_q[g] <= wdata;
      else if (inc) cnt_q[g] <= cnt_q[g] + 1'b1;
  end

  for (genvar r = NG; r < NC; r++) begin : g_run
    logic inc;
    assign inc = (free || !frz) && ((r == NG) ? run_inst : run_cyc);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cnt_q[r] <= '0;
      else if (wr_en && addr == CNT_BASE + AW'(r)) cnt_q[r] <= wdata;
      else if (inc) cnt_q[r] <= cnt_q[r] + 1'b1;
  end

  for (genvar t = 0; t < NC; t++) begin : g_top
    assign tops[t] = cnt_q[t][CW-1];
  end

  wire neg = (|tops[NG-1:0]) || (!free && (|tops[NC-1:NG]));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) alert_q <= 1'b0;
    else alert_q <= a_en && (alert_q || neg);

  assign alert = alert_q;

  always_comb begin
    rdata = '0;
    if (addr == '0) rdata = CW'(ctrl_q);
    else if (addr >= AW'(1) && addr <= AW'(NG)) rdata = CW'(sel_q[addr - AW'(1)]);
    else if (addr >= CNT_BASE && addr < CNT_BASE + AW'(NC)) rdata = cnt_q[addr - CNT_BASE];
  end
endmodule

module perf_monitor_chk #(
  parameter int CW = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [CW-1:0] wdata,
  input logic          run_cyc,
  input logic          alert,
  input logic [3:0]    ctrl,
  input logic [5:0]    tops,
  input logic [CW-1:0] c1,
  input logic [CW-1:0] c6
);
  // R7
  alert_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[1] |=> !alert);
  // R6
  alert_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alert && ctrl[1]) |=> alert);
  // R4
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && !(wr_en && addr == AW'(8))) |=> $stable(c1));
  // R5
  free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[3:2] == 2'b11 && run_cyc && !(wr_en && addr == AW'(13))) |=> c6 == $past(c6) + 1'b1);
  // R8
  free_no_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[3:2] == 2'b11 && !alert && tops[3:0] == 4'b0) |=> !alert);
  // R9
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8)) |=> c1 == $past(wdata));
endmodule

bind perf_monitor perf_monitor_chk #(.CW(CW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .run_cyc(run_cyc), .alert(alert), .ctrl(ctrl_q), .tops(tops),
  .c1(cnt_q[0]), .c6(cnt_q[5]));

// File: tb/perf_monitor_tb.sv
module perf_monitor_tb_top;
  localparam int CLK_NS = 10;
  logic clk = 0, rst_n = 0, wr_en = 0, run_inst = 0, run_cyc = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [15:0] ev = 0;
  logic [31:0] rdata;
  logic alert;
  int checks = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  perf_monitor dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ev(ev), .run_inst(run_inst), .run_cyc(run_cyc), .alert(alert));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  function automatic int ref_evt(input int k, input logic [19:0] c);
    if (c[19:16] != 4'(k)) return -1;
    case (c)
      20'h100F4: return 0;  20'h100FC: return 1;  20'h100F6: return 4;  20'h100F8: return 11;
      20'h200F0: return 2;  20'h200FC: return 3;  20'h200F6: return 10; 20'h200F2: return 12;
      20'h200FA: return 13; 20'h200F8: return 15;
      20'h300F8: return 7;  20'h300F0: return 8;  20'h300FC: return 9;  20'h300F2: return 12;
      20'h400FC: return 5;  20'h400F0: return 6;  20'h400F6: return 14; 20'h400F2: return 12;
      default: return -1;
    endcase
  endfunction

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state and read map
    for (int a = 0; a < 16; a++) begin rd(4'(a), v); check("R10 reset", v, 0); end
    check("R10 alert reset", {31'b0, alert}, 0);
    wr(4'd2, 32'hFFF2_00FA); rd(4'd2, v); check("R10 select width", v, 32'h200FA);
    wr(4'd0, 32'hFFFF_FFF0); rd(4'd0, v); check("R10 ctrl width", v, 0);

    // R1 R2 sweep of counter, code digit and low byte
    for (int k = 1; k <= 4; k++)
      for (int d = 0; d <= 5; d++)
        for (int lo = 8'hF0; lo <= 8'hFE; lo += 2) begin
          logic [19:0] code;
          int e;
          code = {4'(d), 8'h00, 8'(lo)};
          e = ref_evt(k, code);
          wr(4'(k), 32'(code));
          wr(4'(7 + k), 0);
          for (int i = 0; i < 16; i++)
            for (int r = 0; r <= i; r++) begin
              @(negedge clk); ev = 16'(1 << i);
            end
          @(negedge clk); ev = 0;
          rd(4'(7 + k), v);
          if (e >= 0) check("R1 event select", v, 32'(e + 1));
          else check("R2 unknown code", v, 0);
        end

    // R3 run counters
    wr(4'd12, 0); wr(4'd13, 0);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); run_inst = (i % 2 == 0); run_cyc = 1;
    end
    @(negedge clk); run_inst = 0; run_cyc = 0;
    rd(4'd12, v); check("R3 run_inst count", v, 4);
    rd(4'd13, v); check("R3 run_cyc count", v, 7);

    // R4 freeze, mode 0
    wr(4'd1, 32'h100F4); wr(4'd8, 0); wr(4'd12, 0); wr(4'd13, 0);
    wr(4'd0, 32'h1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); ev = 16'h0001; run_inst = 1; run_cyc = 1;
    end
    @(negedge clk); ev = 0; run_inst = 0; run_cyc = 0;
    rd(4'd8, v);  check("R4 frozen c1", v, 0);
    rd(4'd12, v); check("R4 frozen c5", v, 0);
    rd(4'd13, v); check("R4 frozen c6", v, 0);

    // R5 freeze with mode 3
    wr(4'd0, 32'hD);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); ev = 16'h0001; run_inst = 1; run_cyc = 1;
    end
    @(negedge clk); ev = 0; run_inst = 0; run_cyc = 0;
    rd(4'd8, v);  check("R5 c1 still frozen", v, 0);
    rd(4'd12, v); check("R5 c5 counts", v, 5);
    rd(4'd13, v); check("R5 c6 counts", v, 5);

    // R9 write beats increment
    wr(4'd0, 0);
    @(negedge clk); wr_en = 1; addr = 4'd8; wdata = 32'h55; ev = 16'h0001;
    @(negedge clk); wr_en = 0; ev = 0;
    rd(4'd8, v); check("R9 write priority", v, 32'h55);

    // R6 R7 alert from counter 1
    wr(4'd8, 32'h7FFF_FFFF); wr(4'd0, 32'h2);
    @(negedge clk); ev = 16'h0001;
    @(negedge clk); ev = 0;
    check("R6 alert not yet", {31'b0, alert}, 0);
    @(negedge clk); check("R6 alert raised", {31'b0, alert}, 1);
    wr(4'd8, 0);
    repeat (3) @(negedge clk);
    check("R6 alert sticky", {31'b0, alert}, 1);
    wr(4'd0, 0);
    check("R7 alert one cycle late", {31'b0, alert}, 1);
    @(negedge clk); check("R7 alert cleared", {31'b0, alert}, 0);

    // R8 counter 5 negative, mode 0 vs mode 3
    wr(4'd12, 32'h7FFF_FFFF); wr(4'd0, 32'h2);
    @(negedge clk); run_inst = 1;
    @(negedge clk); run_inst = 0;
    @(negedge clk); check("R8 c5 alerts in mode 0", {31'b0, alert}, 1);
    wr(4'd0, 0); wr(4'd12, 32'h7FFF_FFFF); wr(4'd0, 32'hE);
    @(negedge clk); run_inst = 1;
    @(negedge clk); run_inst = 0;
    repeat (3) @(negedge clk);
    check("R8 c5 silent in mode 3", {31'b0, alert}, 0);
    rd(4'd12, v); check("R8 c5 negative", v, 32'h8000_0000);
    wr(4'd13, 32'hFFFF_FFF0);
    repeat (2) @(negedge clk);
    check("R8 c6 silent in mode 3", {31'b0, alert}, 0);
    wr(4'd0, 32'h2);
    repeat (2) @(negedge clk);
    check("R8 alert after leaving mode 3", {31'b0, alert}, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule